// File: doc/BRIEF.md
# USB Dual-Role Port Role Controller

This block decides, one clock step at a time, whether a dual-role USB port behaves as the A-side (host, sourcing VBUS) or as the B-side (peripheral). It watches sampled line-status bits: the ID pin, A-session-valid, A-VBUS-valid, B-session-valid and session-request detection. It also sees attach and detach events reported by the host engine, and single-cycle software requests to ask for the bus, to drop the bus and to clear a VBUS error.

From these it moves through a nine-state role machine. It drives the VBUS supply enable and raises one-cycle strobes that start and stop the host and peripheral engines. It also reports the current state code and a flag telling whether the port is currently the A-side. When the port waits for a B-device to connect, a built-in cycle counter bounds the wait. When that counter expires, the port falls back towards idle.

Top module: `otg_role_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (unset), and `vbus_drv_o`, `default_a_o` and all four strobes are 0. At the first edge after reset the unset state is evaluated as B-idle, so an ID pin held low moves the port straight to A-idle at that edge.
- R2: State codes on `state_o` are: 0 unset, 1 B-idle, 2 B-peripheral, 3 A-idle, 4 A-wait-VBUS-rise, 5 A-wait-B-connect, 6 A-host, 7 A-wait-VBUS-fall, 8 A-VBUS-error. No other code appears.
- R3: From B-idle, a low ID moves to A-idle; otherwise B-session-valid moves to B-peripheral. From B-peripheral, low ID or loss of B-session-valid returns to B-idle. Entering B-peripheral pulses `periph_en_o`. Going from B-peripheral to B-idle pulses `periph_dis_o`.
- R4: From A-idle, a high ID moves to B-idle. Otherwise, with bus drop clear and a bus request or `srp_det_i` set, the port moves to state 4 and `vbus_drv_o` turns on.
- R5: State 4 moves to state 5 on A-VBUS-valid. Entering state 5 from any state other than A-host pulses `host_en_o`; entering it from A-host does not.
- R6: State 5 exits with this priority. First, ID high, bus drop or connect timeout goes to state 7 and clears the bus request. Second, loss of A-VBUS-valid goes to state 8. Third, a recorded attach goes to state 6.
- R7: Entering state 5 restarts the connect-wait counter. With `BCON_TMO_CYC` = N > 0 and no other exit, the port stays in state 5 for exactly N+1 cycles and then enters state 7. A value of 0 disables the timeout.
- R8: From A-host, ID high, a recorded detach or bus drop returns to state 5. Otherwise, loss of A-VBUS-valid goes to state 8.
- R9: Entering state 7 turns `vbus_drv_o` off and forgets any recorded attach. State 7 leaves for A-idle on ID high, on bus request, or on A-session-valid with no recorded attach. That step pulses `host_dis_o`.
- R10: State 8 leaves for state 7 on ID high, on a pending clear-error request or on bus drop, and consumes the clear-error request as it leaves. Without one of these it stays in state 8.
- R11: A bus request is accepted only in B-idle or A-idle, and it clears bus drop. A drop write with value 1 sets bus drop and clears the bus request. A drop write with value 0 clears bus drop. Drop writes and clear-error requests are ignored unless `default_a_o` is 1. Each accepted request takes effect at the edge it is sampled and is seen by the state machine one edge later.
- R12: Entering B-idle clears `default_a_o` and entering A-idle sets it.
- R13: The state advances at most one step per clock edge. Each strobe is high for exactly the one cycle in which `state_o` first shows the state that caused it, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_i | input | 1 | Sampled ID pin (low selects A-side) |
| a_sess_vld_i | input | 1 | A-session-valid line status |
| a_vbus_vld_i | input | 1 | A-VBUS-valid line status |
| b_sess_vld_i | input | 1 | B-session-valid line status |
| srp_det_i | input | 1 | Session request detected from the far end |
| dev_attach_i | input | 1 | One-cycle event: B-device attached (from host engine) |
| dev_detach_i | input | 1 | One-cycle event: B-device detached (from host engine) |
| sw_bus_req_i | input | 1 | One-cycle software request for the bus |
| sw_drop_wr_i | input | 1 | One-cycle software write of the bus-drop flag |
| sw_drop_val_i | input | 1 | Value carried by a bus-drop write |
| sw_clr_err_i | input | 1 | One-cycle software request to clear a VBUS error |
| state_o | output | STATE_W | Current state code (R2) |
| vbus_drv_o | output | 1 | VBUS supply enable |
| host_en_o | output | 1 | Strobe: start host engine |
| host_dis_o | output | 1 | Strobe: stop host engine |
| periph_en_o | output | 1 | Strobe: connect peripheral engine |
| periph_dis_o | output | 1 | Strobe: disconnect peripheral engine |
| default_a_o | output | 1 | Port is currently the A-side |

## Verification
The assertions assume that attach and detach events and the software requests are single-cycle pulses. They also assume that a software clear of a flag never lands on the same edge as a state-machine clear of that same flag. The directed stimulus keeps to this. It changes line bits and pulses only at the falling clock edge. It raises each request alone, for one cycle, while the state in which it is meant to act is stable. It also schedules each A-VBUS-valid drop inside the connect window so that the timeout and the error path never compete by accident.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

   localparam int ROLE_ST_W = 4;

   typedef enum logic [ROLE_ST_W-1:0] {
      ST_UNSET    = 4'd0,
      ST_B_IDLE   = 4'd1,
      ST_B_PERIPH = 4'd2,
      ST_A_IDLE   = 4'd3,
      ST_A_VRISE  = 4'd4,
      ST_A_BCON   = 4'd5,
      ST_A_HOST   = 4'd6,
      ST_A_VFALL  = 4'd7,
      ST_A_VERR   = 4'd8
   } role_st_e;

   typedef struct packed {
      logic id;
      logic a_sess;
      logic a_vbus;
      logic b_sess;
      logic srp;
   } line_t;

   typedef struct packed {
      logic bus_req;
      logic bus_drop;
      logic clr_err;
   } req_t;

   typedef struct packed {
      logic drop_bus_req;
      logic drop_clr_err;
   } req_clr_t;

endpackage

// File: rtl/otg_req_regs.sv
module otg_req_regs
   import otg_role_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  role_st_e state_i,
   input  logic     default_a_i,
   input  logic     sw_bus_req_i,
   input  logic     sw_drop_wr_i,
   input  logic     sw_drop_val_i,
   input  logic     sw_clr_err_i,
   input  req_clr_t clr_i,
   output req_t     req_o
);

   req_t req_q;
   logic idle_st;

   assign idle_st = (state_i == ST_B_IDLE) || (state_i == ST_A_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
      end else begin
         // clears from the role machine first, software writes after
         if (clr_i.drop_bus_req) req_q.bus_req <= 1'b0;
         if (clr_i.drop_clr_err) req_q.clr_err <= 1'b0;
         if (sw_bus_req_i && idle_st) begin
            req_q.bus_req  <= 1'b1;
            req_q.bus_drop <= 1'b0;
         end
         if (sw_drop_wr_i && default_a_i) begin
            if (sw_drop_val_i) begin
               req_q.bus_drop <= 1'b1;
               req_q.bus_req  <= 1'b0;
            end else begin
               req_q.bus_drop <= 1'b0;
            end
         end
         if (sw_clr_err_i && default_a_i) req_q.clr_err <= 1'b1;
      end
   end

   assign req_o = req_q;

endmodule

// File: rtl/otg_conn_track.sv
module otg_conn_track (
   input  logic clk,
   input  logic rst_n,
   input  logic attach_i,
   input  logic detach_i,
   input  logic forget_i,
   output logic conn_o
);

   logic conn_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        conn_q <= 1'b0;
      else if (forget_i) conn_q <= 1'b0;
      else if (detach_i) conn_q <= 1'b0;
      else if (attach_i) conn_q <= 1'b1;
   end

   assign conn_o = conn_q;

endmodule

// File: rtl/otg_bcon_timer.sv
module otg_bcon_timer #(
   parameter int TMO_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   output logic expired_o
);

   generate
      if (TMO_CYC == 0) begin : g_no_tmo
         assign expired_o = 1'b0;
      end else begin : g_tmo
         localparam int          CW   = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC);
         localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

         logic [CW-1:0] cnt_q;
         logic          run_q;
         logic          exp_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
               run_q <= 1'b0;
               exp_q <= 1'b0;
            end else if (stop_i) begin
               cnt_q <= '0;
               run_q <= 1'b0;
               exp_q <= 1'b0;
            end else if (start_i) begin
               cnt_q <= '0;
               run_q <= 1'b1;
               exp_q <= 1'b0;
            end else if (run_q) begin
               if (cnt_q == LAST) begin
                  run_q <= 1'b0;
                  exp_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         assign expired_o = exp_q;
      end
   endgenerate

endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
   import otg_role_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  line_t    line_i,
   input  req_t     req_i,
   input  logic     conn_i,
   input  logic     tmo_i,
   output role_st_e state_o,
   output logic     vbus_o,
   output logic     default_a_o,
   output logic     host_en_o,
   output logic     host_dis_o,
   output logic     periph_en_o,
   output logic     periph_dis_o,
   output logic     tmr_start_o,
   output logic     tmr_stop_o,
   output logic     conn_forget_o,
   output req_clr_t req_clr_o
);

   role_st_e state_q, cur, nxt;
   logic     moved;
   logic     vbus_q, dflt_q;
   logic     hen_q, hdis_q, pen_q, pdis_q;

   // the unset state is folded onto B-idle within the same step
   assign cur = (state_q == ST_UNSET) ? ST_B_IDLE : state_q;

   always_comb begin
      nxt       = cur;
      req_clr_o = '0;
      unique case (cur)
         ST_B_IDLE: begin
            if (!line_i.id)         nxt = ST_A_IDLE;
            else if (line_i.b_sess) nxt = ST_B_PERIPH;
         end
         ST_B_PERIPH: begin
            if (!line_i.b_sess || !line_i.id) nxt = ST_B_IDLE;
         end
         ST_A_IDLE: begin
            if (line_i.id) nxt = ST_B_IDLE;
            else if (!req_i.bus_drop && (req_i.bus_req || line_i.srp))
               nxt = ST_A_VRISE;
         end
         ST_A_VRISE: begin
            if (line_i.a_vbus) nxt = ST_A_BCON;
         end
         ST_A_BCON: begin
            if (line_i.id || req_i.bus_drop || tmo_i) begin
               nxt                    = ST_A_VFALL;
               req_clr_o.drop_bus_req = 1'b1;
            end else if (!line_i.a_vbus) begin
               nxt = ST_A_VERR;
            end else if (conn_i) begin
               nxt = ST_A_HOST;
            end
         end
         ST_A_HOST: begin
            if (line_i.id || !conn_i || req_i.bus_drop) nxt = ST_A_BCON;
            else if (!line_i.a_vbus)                    nxt = ST_A_VERR;
         end
         ST_A_VFALL: begin
            if (line_i.id || (!conn_i && line_i.a_sess) || req_i.bus_req)
               nxt = ST_A_IDLE;
         end
         ST_A_VERR: begin
            if (line_i.id || req_i.clr_err || req_i.bus_drop) begin
               nxt                    = ST_A_VFALL;
               req_clr_o.drop_clr_err = 1'b1;
            end
         end
         default: nxt = ST_B_IDLE;
      endcase
   end

   assign moved         = (nxt != state_q);
   assign tmr_start_o   = moved && (nxt == ST_A_BCON);
   assign tmr_stop_o    = moved && (cur == ST_A_BCON);
   assign conn_forget_o = moved && (nxt == ST_A_VFALL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_UNSET;
         vbus_q  <= 1'b0;
         dflt_q  <= 1'b0;
         hen_q   <= 1'b0;
         hdis_q  <= 1'b0;
         pen_q   <= 1'b0;
         pdis_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         hen_q   <= moved && (nxt == ST_A_BCON) && (state_q != ST_A_HOST);
         hdis_q  <= moved && (nxt == ST_A_IDLE) && (state_q == ST_A_VFALL);
         pen_q   <= moved && (nxt == ST_B_PERIPH);
         pdis_q  <= moved && (nxt == ST_B_IDLE) && (state_q == ST_B_PERIPH);
         if (moved && (nxt == ST_A_VRISE)) vbus_q <= 1'b1;
         if (moved && (nxt == ST_A_VFALL)) vbus_q <= 1'b0;
         if (moved && (nxt == ST_B_IDLE))  dflt_q <= 1'b0;
         if (moved && (nxt == ST_A_IDLE))  dflt_q <= 1'b1;
      end
   end

   assign state_o      = state_q;
   assign vbus_o       = vbus_q;
   assign default_a_o  = dflt_q;
   assign host_en_o    = hen_q;
   assign host_dis_o   = hdis_q;
   assign periph_en_o  = pen_q;
   assign periph_dis_o = pdis_q;

endmodule

// File: rtl/otg_role_ctrl.sv
module otg_role_ctrl
   import otg_role_pkg::*;
#(
   parameter int BCON_TMO_CYC = 1000,
   parameter int STATE_W      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               id_i,
   input  logic               a_sess_vld_i,
   input  logic               a_vbus_vld_i,
   input  logic               b_sess_vld_i,
   input  logic               srp_det_i,
   input  logic               dev_attach_i,
   input  logic               dev_detach_i,
   input  logic               sw_bus_req_i,
   input  logic               sw_drop_wr_i,
   input  logic               sw_drop_val_i,
   input  logic               sw_clr_err_i,
   output logic [STATE_W-1:0] state_o,
   output logic               vbus_drv_o,
   output logic               host_en_o,
   output logic               host_dis_o,
   output logic               periph_en_o,
   output logic               periph_dis_o,
   output logic               default_a_o
);

   generate
      if (STATE_W < ROLE_ST_W) begin : g_bad_state_w
         $error("otg_role_ctrl: STATE_W must be at least %0d", ROLE_ST_W);
      end
      if (BCON_TMO_CYC < 0) begin : g_bad_tmo
         $error("otg_role_ctrl: BCON_TMO_CYC must not be negative");
      end
   endgenerate

   line_t    line;
   req_t     req;
   req_clr_t req_clr;
   role_st_e state;
   logic     conn, tmo, tmr_start, tmr_stop, conn_forget;

   assign line = '{id:     id_i,
                   a_sess: a_sess_vld_i,
                   a_vbus: a_vbus_vld_i,
                   b_sess: b_sess_vld_i,
                   srp:    srp_det_i};

   otg_req_regs u_req (
      .clk           (clk),
      .rst_n         (rst_n),
      .state_i       (state),
      .default_a_i   (default_a_o),
      .sw_bus_req_i  (sw_bus_req_i),
      .sw_drop_wr_i  (sw_drop_wr_i),
      .sw_drop_val_i (sw_drop_val_i),
      .sw_clr_err_i  (sw_clr_err_i),
      .clr_i         (req_clr),
      .req_o         (req)
   );

   otg_conn_track u_conn (
      .clk      (clk),
      .rst_n    (rst_n),
      .attach_i (dev_attach_i),
      .detach_i (dev_detach_i),
      .forget_i (conn_forget),
      .conn_o   (conn)
   );

   otg_bcon_timer #(.TMO_CYC(BCON_TMO_CYC)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (tmr_start),
      .stop_i    (tmr_stop),
      .expired_o (tmo)
   );

   otg_role_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .line_i        (line),
      .req_i         (req),
      .conn_i        (conn),
      .tmo_i         (tmo),
      .state_o       (state),
      .vbus_o        (vbus_drv_o),
      .default_a_o   (default_a_o),
      .host_en_o     (host_en_o),
      .host_dis_o    (host_dis_o),
      .periph_en_o   (periph_en_o),
      .periph_dis_o  (periph_dis_o),
      .tmr_start_o   (tmr_start),
      .tmr_stop_o    (tmr_stop),
      .conn_forget_o (conn_forget),
      .req_clr_o     (req_clr)
   );

   assign state_o = STATE_W'(state);

endmodule

// File: rtl/otg_role_chk.sv
module otg_role_chk #(
   parameter int BCON_TMO_CYC = 1000,
   parameter int STATE_W      = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [STATE_W-1:0] state_o,
   input logic               vbus_drv_o,
   input logic               host_en_o,
   input logic               host_dis_o,
   input logic               periph_en_o,
   input logic               periph_dis_o,
   input logic               default_a_o
);

   localparam int WW = $clog2(BCON_TMO_CYC + 2) + 1;
   logic [WW-1:0] bcon_run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                         bcon_run_q <= '0;
      else if (state_o == STATE_W'(5))    bcon_run_q <= bcon_run_q + 1'b1;
      else                                bcon_run_q <= '0;
   end

   // R2
   state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= STATE_W'(8));

   // R4
   vbus_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vbus_drv_o) |-> state_o == STATE_W'(4));

   // R9
   vfall_vbus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == STATE_W'(7) |-> !vbus_drv_o);

   // R5
   host_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_en_o |-> (state_o == STATE_W'(5)) && ($past(state_o) != STATE_W'(6)));

   // R3
   periph_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_en_o |-> (state_o == STATE_W'(2)) && ($past(state_o) != STATE_W'(2)));

   // R12
   default_a_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == STATE_W'(3) |-> default_a_o);

   // R12
   default_b_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == STATE_W'(1)) || (state_o == STATE_W'(2)) |-> !default_a_o);

   // R13
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({host_en_o, host_dis_o, periph_en_o, periph_dis_o}));

   generate
      if (BCON_TMO_CYC != 0) begin : g_window
         // R7
         bcon_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            state_o == STATE_W'(5) |-> bcon_run_q <= WW'(BCON_TMO_CYC));
      end
   endgenerate

endmodule

bind otg_role_ctrl otg_role_chk #(
   .BCON_TMO_CYC (BCON_TMO_CYC),
   .STATE_W      (STATE_W)
) u_role_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .state_o      (state_o),
   .vbus_drv_o   (vbus_drv_o),
   .host_en_o    (host_en_o),
   .host_dis_o   (host_dis_o),
   .periph_en_o  (periph_en_o),
   .periph_dis_o (periph_dis_o),
   .default_a_o  (default_a_o)
);

// File: tb/tb_otg_role_ctrl.sv
`timescale 1ns/1ps
module tb_otg_role_ctrl;

   localparam int TMO = 8;
   localparam logic [3:0] S_UN = 4'd0, S_BI = 4'd1, S_BP = 4'd2, S_AI = 4'd3,
                          S_VR = 4'd4, S_BC = 4'd5, S_AH = 4'd6, S_VF = 4'd7,
                          S_VE = 4'd8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic id = 1'b1, a_sess = 1'b0, a_vbus = 1'b0, b_sess = 1'b0, srp = 1'b0;
   logic attach = 1'b0, detach = 1'b0;
   logic bus_req = 1'b0, drop_wr = 1'b0, drop_val = 1'b0, clr_err = 1'b0;
   logic [3:0] state;
   logic vbus, hen, hdis, pen, pdis, dflt;
   int   tests = 0;
   int   fails = 0;

   always #2.5 clk = ~clk;

   otg_role_ctrl #(.BCON_TMO_CYC(TMO), .STATE_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .id_i(id), .a_sess_vld_i(a_sess),
      .a_vbus_vld_i(a_vbus), .b_sess_vld_i(b_sess), .srp_det_i(srp),
      .dev_attach_i(attach), .dev_detach_i(detach), .sw_bus_req_i(bus_req),
      .sw_drop_wr_i(drop_wr), .sw_drop_val_i(drop_val), .sw_clr_err_i(clr_err),
      .state_o(state), .vbus_drv_o(vbus), .host_en_o(hen), .host_dis_o(hdis),
      .periph_en_o(pen), .periph_dis_o(pdis), .default_a_o(dflt));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_st(input string req, input logic [3:0] exp);
      chk(req, "state", int'(state), int'(exp));
   endtask

   task automatic do_reset(input logic id_val, input logic [3:0] exp_after);
      rst_n = 1'b0; id = id_val; a_sess = 0; a_vbus = 0; b_sess = 0; srp = 0;
      attach = 0; detach = 0; bus_req = 0; drop_wr = 0; drop_val = 0; clr_err = 0;
      repeat (3) tick();
      chk_st("R1", S_UN);
      chk("R1", "outputs in reset", int'({vbus, hen, hdis, pen, pdis, dflt}), 0);
      rst_n = 1'b1;
      tick();
      chk_st("R1", exp_after);
   endtask

   task automatic req_pulse();
      bus_req = 1'b1; tick(); bus_req = 1'b0;
   endtask

   task automatic drop_pulse(input logic v);
      drop_wr = 1'b1; drop_val = v; tick(); drop_wr = 1'b0; drop_val = 1'b0;
   endtask

   // R3, R13: peripheral path and one-step-per-edge chaining
   task automatic t_periph();
      b_sess = 1; tick();
      chk_st("R3", S_BP); chk("R3", "periph_en", int'(pen), 1);
      tick(); chk("R13", "periph_en width", int'(pen), 0);
      b_sess = 0; tick();
      chk_st("R3", S_BI); chk("R3", "periph_dis", int'(pdis), 1);
      b_sess = 1; id = 0; tick();
      chk_st("R3", S_AI); chk("R12", "default_a set", int'(dflt), 1);
      id = 1; tick(); chk_st("R12", S_BI); chk("R12", "default_a clr", int'(dflt), 0);
      tick(); chk_st("R3", S_BP);
      id = 0; tick(); chk_st("R13", S_BI); chk("R3", "periph_dis id", int'(pdis), 1);
      tick(); chk_st("R13", S_AI);
      b_sess = 0; id = 1; tick(); chk_st("R4", S_BI);
   endtask

   // R11: drop write ignored while on the B side, then SRP starts a session
   task automatic t_ignored_drop();
      drop_pulse(1'b1);
      id = 0; tick(); chk_st("R11", S_AI);
      srp = 1; tick();
      chk_st("R11", S_VR); chk("R4", "vbus on", int'(vbus), 1);
      srp = 0;
   endtask

   // R5, R6, R8, R9, R10: host entry, detach, error and recovery
   task automatic t_host_detach();
      a_vbus = 1; tick();
      chk_st("R5", S_BC); chk("R5", "host_en", int'(hen), 1);
      attach = 1; tick(); attach = 0;
      chk_st("R6", S_BC); chk("R13", "host_en width", int'(hen), 0);
      tick(); chk_st("R6", S_AH);
      detach = 1; tick(); detach = 0; chk_st("R8", S_AH);
      tick(); chk_st("R8", S_BC); chk("R5", "no host_en from host", int'(hen), 0);
      a_vbus = 0; tick(); chk_st("R6", S_VE); chk("R6", "vbus kept", int'(vbus), 1);
      tick(); chk_st("R10", S_VE);
      clr_err = 1; tick(); clr_err = 0; chk_st("R10", S_VE);
      tick(); chk_st("R10", S_VF); chk("R9", "vbus off", int'(vbus), 0);
      tick(); chk_st("R9", S_VF);
      a_sess = 1; tick();
      chk_st("R9", S_AI); chk("R9", "host_dis", int'(hdis), 1);
      a_sess = 0;
   endtask

   // R7: connect-wait timeout length and bus request cleared
   task automatic t_timeout();
      a_vbus = 1;
      req_pulse(); chk_st("R11", S_AI);
      tick(); chk_st("R4", S_VR);
      tick(); chk_st("R7", S_BC);
      for (int i = 0; i < TMO; i++) begin
         tick(); chk_st("R7", S_BC);
      end
      tick(); chk_st("R7", S_VF);
      tick(); tick(); chk_st("R7", S_VF);
      a_sess = 1; tick(); chk_st("R9", S_AI); a_sess = 0;
   endtask

   // R6: first-level exit beats VBUS loss
   task automatic t_prio1();
      req_pulse(); tick(); chk_st("R4", S_VR);
      tick(); chk_st("R6", S_BC);
      id = 1; a_vbus = 0; tick(); chk_st("R6", S_VF);
      tick(); chk_st("R9", S_AI); chk("R9", "host_dis id", int'(hdis), 1);
      tick(); chk_st("R4", S_BI); chk("R12", "default_a", int'(dflt), 0);
      id = 0; a_vbus = 1; tick(); chk_st("R11", S_AI);
      tick(); chk_st("R7", S_AI);
   endtask

   // R6, R10, R11: VBUS loss beats attach; drop clears request
   task automatic t_prio2();
      req_pulse(); tick(); tick(); chk_st("R6", S_BC);
      attach = 1; tick(); attach = 0; chk_st("R6", S_BC);
      a_vbus = 0; tick(); chk_st("R6", S_VE);
      tick(); chk_st("R10", S_VE);
      drop_pulse(1'b1); chk_st("R10", S_VE);
      tick(); chk_st("R10", S_VF);
      tick(); chk_st("R11", S_VF);
      a_sess = 1; drop_pulse(1'b0); chk_st("R9", S_AI);
      a_sess = 0; a_vbus = 1;
   endtask

   // R8, R11: bus drop from host; request ignored outside idle
   task automatic t_host_drop();
      req_pulse(); tick(); tick(); chk_st("R5", S_BC);
      attach = 1; tick(); attach = 0; tick(); chk_st("R8", S_AH);
      drop_pulse(1'b1); chk_st("R8", S_AH);
      tick(); chk_st("R8", S_BC); chk("R5", "host_en", int'(hen), 0);
      tick(); chk_st("R6", S_VF);
      tick(); chk_st("R11", S_VF);
      req_pulse(); tick(); chk_st("R11", S_VF);
      a_sess = 1; drop_pulse(1'b0); chk_st("R9", S_AI);
      a_sess = 0;
   endtask

   // R8, R10: VBUS loss in host, ID exit from error
   task automatic t_host_vbus();
      req_pulse(); tick(); tick(); chk_st("R5", S_BC);
      attach = 1; tick(); attach = 0; tick(); chk_st("R8", S_AH);
      a_vbus = 0; tick(); chk_st("R8", S_VE);
      id = 1; tick(); chk_st("R10", S_VF);
      tick(); chk_st("R9", S_AI);
      tick(); chk_st("R4", S_BI);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset(1'b0, S_AI);
      chk("R12", "default_a after reset", int'(dflt), 1);
      do_reset(1'b1, S_BI);
      t_periph();
      t_ignored_drop();
      t_host_detach();
      t_timeout();
      t_prio1();
      t_prio2();
      t_host_drop();
      t_host_vbus();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule